// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that copies data words between a peripheral FIFO and system memory, following a chain of descriptors that software has placed in memory. Software writes the byte address of the first descriptor into the pointer register and then sets the start bit. The channel reads the five-word descriptor, loads its working registers from it, and moves the block one word at a time. Each word is read at the source address and then written at the destination address. Transfers are paced by a request/acknowledge handshake with the peripheral: each request moves one chunk of items, and the channel then returns a single acknowledge pulse.

After a block finishes, the channel examines the descriptor's link word. A non-zero link makes the channel fetch the next descriptor at that address and continue. A zero link ends the chain. The channel then returns to idle and raises a completion flag. An error response from memory on any access aborts the channel and raises an error flag instead. Both flags clear when the status register is read.

Top module: `dma_ll_chan`

## Requirements
- R1: After reset the channel is idle: the busy bit (bit 0 of register 0) reads 0, the status register (register 2) reads 0, and memValid and perAck are low.
- R2: Writing a word with bit 0 set to register 0 while idle starts the channel. It issues five consecutive word reads at pointer+0, +4, +8, +12 and +16, taking in turn the source address, destination address, control A, control B and link word. No data access happens before all five are loaded, and bit 0 of register 0 reads 1 while the channel is active.
- R3: Control A bits [15:0] give the item count in words, and bits [23:16] give the items per request, where 0 means 1. In control B, bit 0 makes the source address advance and bit 1 makes the destination address advance. Control B (register 3) is writable while idle, and each fetch overwrites it. Register 4 reads control A, register 5 the current source and register 6 the current destination.
- R4: Each item is a read at the source address followed by a write of that word at the destination address. An address whose increment bit is clear stays fixed; otherwise it advances by 4 after each access.
- R5: No data access starts until perReq is high. One request moves min(chunk, remaining) items, so the last chunk may be partial.
- R6: perAck is a single-cycle pulse in the cycle after the write of the chunk's last item is accepted.
- R7: A non-zero link word makes the channel fetch the next descriptor at that address, and the pointer register then reads that address. A zero link word stops the channel: the busy bit clears and status bit 0 (chain done) is set.
- R8: Reading register 2 returns the status bits and clears them. A start or a pointer write while the channel is busy has no effect.
- R9: A memory error response on any access stops the channel at once. The busy bit clears, status bit 1 is set and no further memory access occurs.
- R10: A descriptor with an item count of zero moves no data and passes directly to its link.
- R11: While memValid is high and memReady is low, memValid, memWrite and memAddr hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (a status read clears the status) |
| regAddr | input | 3 | Register word index |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data, valid while regRdEn is high |
| memValid | output | 1 | Memory access request |
| memWrite | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Byte address of the access |
| memWData | output | DATA_W | Write data |
| memReady | input | 1 | Access accepted this cycle |
| memRData | input | DATA_W | Read data, valid with memReady |
| memErr | input | 1 | Error response, qualified by memReady |
| perReq | input | 1 | Peripheral chunk request |
| perAck | output | 1 | One-cycle chunk acknowledge |

## Verification
The bench uses the default parameters: 32-bit addresses and data, a 16-bit item count and an 8-bit chunk field. These widths give direct access to a chunk value of zero, to chunks larger than the remaining count, and to a zero-length descriptor in the middle of a chain. A small word memory with a pop-on-read FIFO port makes fixed-source and incrementing-destination transfers visible. A toggling memReady exercises stalled accesses, and an address-matched error response exercises the abort path.

// File: rtl/dma_ll_pkg.sv
package dma_ll_pkg;

  localparam int REG_AW     = 3;
  localparam int DESC_WORDS = 5;

  localparam logic [REG_AW-1:0] REG_CTRL   = 3'd0;
  localparam logic [REG_AW-1:0] REG_PTR    = 3'd1;
  localparam logic [REG_AW-1:0] REG_STATUS = 3'd2;
  localparam logic [REG_AW-1:0] REG_CTLB   = 3'd3;
  localparam logic [REG_AW-1:0] REG_CTLA   = 3'd4;
  localparam logic [REG_AW-1:0] REG_SRC    = 3'd5;
  localparam logic [REG_AW-1:0] REG_DST    = 3'd6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_BLKCHK, ST_WAITREQ, ST_RD, ST_WR, ST_ACK, ST_ENDBLK
  } chanState_t;

  typedef enum logic [1:0] {ADDR_DESC, ADDR_SRC, ADDR_DST} addrSel_t;

  typedef struct packed {
    logic       ldEn;
    logic [2:0] ldIdx;
    logic       latch;
    logic       advSrc;
    logic       advDst;
    logic       chunkLoad;
    logic       itemDone;
    logic       nextDesc;
    logic       setDone;
    logic       setErr;
    addrSel_t   addrSel;
  } dpCmd_t;

  typedef struct packed {
    logic remZero;
    logic chunkLast;
    logic nextZero;
  } dpStat_t;

endpackage

// File: rtl/dma_ll_ctrl.sv
module dma_ll_ctrl
  import dma_ll_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    memReady,
  input  logic    memErr,
  input  logic    perReq,
  input  dpStat_t stat,
  output dpCmd_t  cmd,
  output logic    memValid,
  output logic    memWrite,
  output logic    perAck,
  output logic    chanBusy
);

  localparam logic [2:0] LAST_IDX = 3'(DESC_WORDS - 1);

  chanState_t stateQ, stateD;
  logic [2:0] idxQ, idxD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      idxQ   <= '0;
    end else begin
      stateQ <= stateD;
      idxQ   <= idxD;
    end
  end

  always_comb begin
    cmd         = '0;
    cmd.ldIdx   = idxQ;
    cmd.addrSel = ADDR_DESC;
    memValid    = 1'b0;
    memWrite    = 1'b0;
    perAck      = 1'b0;
    stateD      = stateQ;
    idxD        = idxQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (startReq) begin
          stateD = ST_FETCH;
          idxD   = '0;
        end
      end
      ST_FETCH: begin
        memValid = 1'b1;
        if (memReady) begin
          if (memErr) begin
            cmd.setErr = 1'b1;
            stateD     = ST_IDLE;
          end else begin
            cmd.ldEn = 1'b1;
            if (idxQ == LAST_IDX) stateD = ST_BLKCHK;
            else idxD = idxQ + 3'd1;
          end
        end
      end
      ST_BLKCHK: stateD = stat.remZero ? ST_ENDBLK : ST_WAITREQ;
      ST_WAITREQ: begin
        if (perReq) begin
          cmd.chunkLoad = 1'b1;
          stateD        = ST_RD;
        end
      end
      ST_RD: begin
        cmd.addrSel = ADDR_SRC;
        memValid    = 1'b1;
        if (memReady) begin
          if (memErr) begin
            cmd.setErr = 1'b1;
            stateD     = ST_IDLE;
          end else begin
            cmd.latch  = 1'b1;
            cmd.advSrc = 1'b1;
            stateD     = ST_WR;
          end
        end
      end
      ST_WR: begin
        cmd.addrSel = ADDR_DST;
        memValid    = 1'b1;
        memWrite    = 1'b1;
        if (memReady) begin
          if (memErr) begin
            cmd.setErr = 1'b1;
            stateD     = ST_IDLE;
          end else begin
            cmd.advDst   = 1'b1;
            cmd.itemDone = 1'b1;
            stateD       = stat.chunkLast ? ST_ACK : ST_RD;
          end
        end
      end
      ST_ACK: begin
        perAck = 1'b1;
        stateD = stat.remZero ? ST_ENDBLK : ST_WAITREQ;
      end
      ST_ENDBLK: begin
        if (stat.nextZero) begin
          cmd.setDone = 1'b1;
          stateD      = ST_IDLE;
        end else begin
          cmd.nextDesc = 1'b1;
          stateD       = ST_FETCH;
          idxD         = '0;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign chanBusy = (stateQ != ST_IDLE);

endmodule

// File: rtl/dma_ll_dp.sv
module dma_ll_dp
  import dma_ll_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int CHUNK_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              chanBusy,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [DATA_W-1:0] memRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output dpStat_t           stat
);

  localparam int          STEP_SH   = $clog2(DATA_W / 8);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);
  localparam int          CHUNK_LSB = CNT_W;

  logic [ADDR_W-1:0] ptrQ, srcQ, dstQ, nextQ;
  logic [DATA_W-1:0] ctrlAQ, ctrlBQ, dataQ;
  logic [CNT_W-1:0]  remQ, chunkQ, chunkEff, chunkInit;
  logic              doneQ, errQ;
  logic [ADDR_W-1:0] descAddr;
  logic [CHUNK_W-1:0] chunkField;
  logic              rdStatus, idleWr;

  assign descAddr   = ptrQ + (ADDR_W'(cmd.ldIdx) << STEP_SH);
  assign chunkField = ctrlAQ[CHUNK_LSB +: CHUNK_W];
  assign chunkEff   = (chunkField == '0) ? CNT_W'(1) : CNT_W'(chunkField);
  assign chunkInit  = (chunkEff < remQ) ? chunkEff : remQ;
  assign rdStatus   = regRdEn && (regAddr == REG_STATUS);
  assign idleWr     = regWrEn && !chanBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ   <= '0;
      srcQ   <= '0;
      dstQ   <= '0;
      nextQ  <= '0;
      ctrlAQ <= '0;
      ctrlBQ <= '0;
      dataQ  <= '0;
      remQ   <= '0;
      chunkQ <= '0;
    end else begin
      if (idleWr && regAddr == REG_PTR)  ptrQ   <= regWrData[ADDR_W-1:0];
      if (idleWr && regAddr == REG_CTLB) ctrlBQ <= regWrData;
      if (cmd.ldEn) begin
        unique case (cmd.ldIdx)
          3'd0: srcQ <= memRData[ADDR_W-1:0];
          3'd1: dstQ <= memRData[ADDR_W-1:0];
          3'd2: begin
            ctrlAQ <= memRData;
            remQ   <= memRData[CNT_W-1:0];
          end
          3'd3: ctrlBQ <= memRData;
          default: nextQ <= memRData[ADDR_W-1:0];
        endcase
      end
      if (cmd.latch) dataQ <= memRData;
      if (cmd.advSrc && ctrlBQ[0]) srcQ <= srcQ + STEP;
      if (cmd.advDst && ctrlBQ[1]) dstQ <= dstQ + STEP;
      if (cmd.chunkLoad) chunkQ <= chunkInit;
      if (cmd.itemDone) begin
        remQ   <= remQ - CNT_W'(1);
        chunkQ <= chunkQ - CNT_W'(1);
      end
      if (cmd.nextDesc) ptrQ <= nextQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      doneQ <= cmd.setDone | (doneQ & ~rdStatus);
      errQ  <= cmd.setErr  | (errQ  & ~rdStatus);
    end
  end

  always_comb begin
    unique case (cmd.addrSel)
      ADDR_SRC: memAddr = srcQ;
      ADDR_DST: memAddr = dstQ;
      default:  memAddr = descAddr;
    endcase
  end

  assign memWData = dataQ;

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      unique case (regAddr)
        REG_CTRL:   regRdData = DATA_W'(chanBusy);
        REG_PTR:    regRdData = DATA_W'(ptrQ);
        REG_STATUS: regRdData = DATA_W'({errQ, doneQ});
        REG_CTLB:   regRdData = ctrlBQ;
        REG_CTLA:   regRdData = ctrlAQ;
        REG_SRC:    regRdData = DATA_W'(srcQ);
        REG_DST:    regRdData = DATA_W'(dstQ);
        default:    regRdData = '0;
      endcase
    end
  end

  assign stat.remZero   = (remQ == '0);
  assign stat.chunkLast = (chunkQ == CNT_W'(1));
  assign stat.nextZero  = (nextQ == '0);

endmodule

// File: rtl/dma_ll_chan.sv
module dma_ll_chan
  import dma_ll_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int CHUNK_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRData,
  input  logic              memErr,
  input  logic              perReq,
  output logic              perAck
);

  dpCmd_t  cmd;
  dpStat_t stat;
  logic    chanBusy;
  logic    startReq;

  assign startReq = regWrEn && (regAddr == REG_CTRL) && regWrData[0];

  dma_ll_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .memReady (memReady),
    .memErr   (memErr),
    .perReq   (perReq),
    .stat     (stat),
    .cmd      (cmd),
    .memValid (memValid),
    .memWrite (memWrite),
    .perAck   (perAck),
    .chanBusy (chanBusy)
  );

  dma_ll_dp #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .CHUNK_W (CHUNK_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .chanBusy  (chanBusy),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .memRData  (memRData),
    .memAddr   (memAddr),
    .memWData  (memWData),
    .stat      (stat)
  );

endmodule

// File: rtl/dma_ll_chk.sv
module dma_ll_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memValid,
  input logic              memReady,
  input logic              memWrite,
  input logic              memErr,
  input logic [ADDR_W-1:0] memAddr,
  input logic              perAck,
  input logic              chanBusy
);

  // R6
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    perAck |=> !perAck);

  // R6
  ack_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    perAck |-> $past(memValid && memReady && memWrite && !memErr));

  // R11
  hold_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWrite)));

  // R9
  err_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady && memErr) |=> !chanBusy);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chanBusy |-> (!memValid && !perAck));

endmodule

bind dma_ll_chan dma_ll_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .memValid (memValid),
  .memReady (memReady),
  .memWrite (memWrite),
  .memErr   (memErr),
  .memAddr  (memAddr),
  .perAck   (perAck),
  .chanBusy (chanBusy)
);

// File: tb/dma_ll_chan_bench.sv
module dma_ll_chan_bench;

  localparam logic [31:0] FIFO_ADDR = 32'h800;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic        memValid, memWrite, memReady = 1'b1, memErr, perReq = 1'b0, perAck;
  logic [31:0] memAddr, memWData, memRData;

  logic [31:0] mem [0:255];
  logic [31:0] fifoNext = 32'hA000;
  logic [31:0] errAddr = 32'hFFFF_FFF0;
  logic        stallMode = 1'b0, autoReq = 1'b0;
  logic [31:0] logAddr [0:511];
  logic        logWr [0:511];
  int          logCnt = 0, ackCnt = 0, wrSince = 0;
  int          chunkLog [0:63];
  int          testCnt = 0, failCnt = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  dma_ll_chan u_dma_ll_chan (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memValid(memValid), .memWrite(memWrite),
    .memAddr(memAddr), .memWData(memWData), .memReady(memReady), .memRData(memRData),
    .memErr(memErr), .perReq(perReq), .perAck(perAck)
  );

  assign memRData = (memAddr == FIFO_ADDR) ? fifoNext : mem[memAddr[9:2]];
  assign memErr   = memValid && (memAddr == errAddr);

  always @(posedge clk) begin
    if (rstN && memValid && memReady) begin
      if (logCnt < 512) begin
        logAddr[logCnt] = memAddr;
        logWr[logCnt]   = memWrite;
      end
      logCnt++;
      if (!memErr) begin
        if (memWrite) begin
          mem[memAddr[9:2]] <= memWData;
          wrSince++;
        end else if (memAddr == FIFO_ADDR) fifoNext <= fifoNext + 1;
      end
    end
    if (rstN && perAck) begin
      if (ackCnt < 64) chunkLog[ackCnt] = wrSince;
      ackCnt++;
      wrSince = 0;
    end
  end

  always @(negedge clk) begin
    memReady <= stallMode ? ~memReady : 1'b1;
    if (perAck) perReq <= 1'b0;
    else if (autoReq && !perReq) perReq <= 1'b1;
    else if (!autoReq) perReq <= 1'b0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic putDesc(input logic [31:0] base, input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] ca, input logic [31:0] cb, input logic [31:0] nx);
    mem[base[9:2]]     = s;
    mem[base[9:2] + 1] = d;
    mem[base[9:2] + 2] = ca;
    mem[base[9:2] + 3] = cb;
    mem[base[9:2] + 4] = nx;
  endtask

  task automatic clearLogs();
    @(negedge clk);
    logCnt = 0; ackCnt = 0; wrSince = 0;
  endtask

  task automatic waitIdle(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      regRead(3'd0, v);
      if (v[0] == 1'b0) return;
    end
    chk({tag, " timeout"}, 32'd1, 32'd0);
  endtask

  task automatic startChain(input logic [31:0] ptr);
    regWrite(3'd3, 32'd0);
    regWrite(3'd1, ptr);
    regWrite(3'd0, 32'd1);
  endtask

  task automatic testReset();
    logic [31:0] v;
    chk("R1 memValid", {31'd0, memValid}, 32'd0);
    chk("R1 perAck", {31'd0, perAck}, 32'd0);
    regRead(3'd0, v); chk("R1 busy", v, 32'd0);
    regRead(3'd2, v); chk("R1 status", v, 32'd0);
  endtask

  task automatic testCtrlBIdle();
    logic [31:0] v;
    regWrite(3'd3, 32'd3);
    regRead(3'd3, v); chk("R3 ctrlB write idle", v, 32'd3);
    regWrite(3'd3, 32'd0);
    regRead(3'd3, v); chk("R3 ctrlB zero", v, 32'd0);
  endtask

  task automatic testSingle();
    logic [31:0] v;
    fifoNext = 32'hA000;
    putDesc(32'h40, FIFO_ADDR, 32'h300, (32'd4 << 16) | 32'd6, 32'd2, 32'd0);
    clearLogs();
    startChain(32'h40);
    repeat (20) @(negedge clk);
    chk("R2 five fetch reads only", logCnt, 32'd5);
    for (int i = 0; i < 5; i++) begin
      chk("R2 fetch addr", logAddr[i], 32'h40 + 4 * i);
      chk("R2 fetch is read", {31'd0, logWr[i]}, 32'd0);
    end
    regRead(3'd0, v); chk("R2 busy while active", v, 32'd1);
    autoReq = 1'b1;
    waitIdle("R7 single");
    autoReq = 1'b0;
    for (int i = 0; i < 6; i++) chk("R4 fifo to mem data", mem[(32'h300 >> 2) + i], 32'hA000 + i);
    chk("R4 src fixed", logAddr[5], FIFO_ADDR);
    chk("R4 src fixed later", logAddr[7], FIFO_ADDR);
    chk("R5 ack count", ackCnt, 32'd2);
    chk("R5 full chunk", chunkLog[0], 32'd4);
    chk("R5 partial chunk", chunkLog[1], 32'd2);
    regRead(3'd6, v); chk("R4 dst advanced", v, 32'h318);
    regRead(3'd5, v); chk("R4 src held", v, FIFO_ADDR);
    regRead(3'd2, v); chk("R7 done bit", v, 32'd1);
    regRead(3'd2, v); chk("R8 status cleared by read", v, 32'd0);
  endtask

  task automatic testChain();
    logic [31:0] v;
    fifoNext = 32'hB000;
    mem[32'h20 >> 2] = 32'hDEAD;
    for (int i = 0; i < 4; i++) mem[(32'h180 >> 2) + i] = 32'h11 * (i + 1);
    putDesc(32'h40, FIFO_ADDR, 32'h100, (32'd2 << 16) | 32'd3, 32'd2, 32'h60);
    putDesc(32'h60, 32'h10, 32'h20, (32'd5 << 16), 32'd3, 32'h80);
    putDesc(32'h80, 32'h180, 32'h1C0, 32'd4, 32'd3, 32'd0);
    clearLogs();
    autoReq = 1'b1;
    startChain(32'h40);
    waitIdle("R7 chain");
    autoReq = 1'b0;
    for (int i = 0; i < 3; i++) chk("R7 first block data", mem[(32'h100 >> 2) + i], 32'hB000 + i);
    for (int i = 0; i < 4; i++) chk("R4 mem to mem data", mem[(32'h1C0 >> 2) + i], 32'h11 * (i + 1));
    chk("R10 zero block untouched", mem[32'h20 >> 2], 32'hDEAD);
    chk("R7 second fetch addr", logAddr[11], 32'h60);
    chk("R10 third fetch follows", logAddr[16], 32'h80);
    chk("R10 total accesses", logCnt, 32'd29);
    chk("R3 chunk zero means one, acks", ackCnt, 32'd6);
    chk("R5 chain partial", chunkLog[1], 32'd1);
    chk("R3 chunk one", chunkLog[5], 32'd1);
    regRead(3'd1, v); chk("R7 pointer follows link", v, 32'h80);
    regRead(3'd4, v); chk("R3 ctrlA reload", v, 32'd4);
    regRead(3'd3, v); chk("R3 ctrlB reload", v, 32'd3);
    regRead(3'd5, v); chk("R4 src incremented", v, 32'h190);
    regRead(3'd6, v); chk("R4 dst incremented", v, 32'h1D0);
    regRead(3'd2, v); chk("R7 chain done", v, 32'd1);
  endtask

  task automatic testBusyIgnore();
    logic [31:0] v;
    fifoNext = 32'hC000;
    putDesc(32'h40, FIFO_ADDR, 32'h340, (32'd2 << 16) | 32'd2, 32'd2, 32'd0);
    clearLogs();
    startChain(32'h40);
    repeat (10) @(negedge clk);
    regWrite(3'd1, 32'h99C);
    regWrite(3'd0, 32'd1);
    regRead(3'd1, v); chk("R8 ptr write ignored while busy", v, 32'h40);
    autoReq = 1'b1;
    waitIdle("R8 busy");
    autoReq = 1'b0;
    repeat (20) @(negedge clk);
    chk("R8 start ignored, no refetch", logCnt, 32'd9);
    chk("R8 data", mem[(32'h344) >> 2], 32'hC001);
    regRead(3'd2, v); chk("R8 single done", v, 32'd1);
  endtask

  task automatic testError();
    logic [31:0] v;
    errAddr = 32'h3F0;
    putDesc(32'h40, FIFO_ADDR, 32'h3F0, (32'd1 << 16) | 32'd3, 32'd2, 32'h60);
    clearLogs();
    autoReq = 1'b1;
    startChain(32'h40);
    waitIdle("R9 error");
    repeat (20) @(negedge clk);
    autoReq = 1'b0;
    chk("R9 accesses stop", logCnt, 32'd7);
    chk("R9 no ack", ackCnt, 32'd0);
    regRead(3'd2, v); chk("R9 error bit", v, 32'd2);
    errAddr = 32'hFFFF_FFF0;
  endtask

  task automatic testStall();
    fifoNext = 32'hD000;
    putDesc(32'h40, FIFO_ADDR, 32'h380, (32'd3 << 16) | 32'd5, 32'd2, 32'd0);
    clearLogs();
    stallMode = 1'b1;
    autoReq = 1'b1;
    startChain(32'h40);
    waitIdle("R11 stall");
    autoReq = 1'b0;
    stallMode = 1'b0;
    for (int i = 0; i < 5; i++) chk("R11 stalled data", mem[(32'h380 >> 2) + i], 32'hD000 + i);
    chk("R5 stalled chunk a", chunkLog[0], 32'd3);
    chk("R5 stalled chunk b", chunkLog[1], 32'd2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCtrlBIdle();
    testSingle();
    testChain();
    testBusyIgnore();
    testError();
    testStall();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule